// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is one direction of a packet DMA engine. It works through a circular list of descriptors in system memory. Each descriptor takes two 32-bit words: a status word, then a buffer pointer. The channel reads the status word at its current ring position. It acts on the descriptor only when the ownership bit says the hardware holds it. It then moves one whole frame between the buffer and a byte stream. Finally it writes the status back with a done flag set and ownership returned to software, and steps to the next slot.

The parameter `RX_MODE` fixes the direction. In transmit mode, buffer bytes go out on the `out_*` stream. In receive mode, bytes arriving on the `in_*` stream are stored into the buffer. Software configures the channel through a small write-only register port:

| Address | Register |
|---------|----------|
| 0 | descriptor base |
| 1 | ring length, as a descriptor count |
| 2 | control: bit 0 enable, bit 1 reset |
| 3 | idle re-read interval, in cycles |

Memory is reached through a single-beat port with byte enables. Its read data returns one cycle after the request.

Top module: `ring_dma_chan`

## Requirements
- R1: After `rst`, `mem_req`, `out_valid` and `in_ready` are low, the ring index is 0, the channel is disabled and the re-read interval equals `POLL_DEF`.
- R2: Descriptor i has its status at byte address base+8*i and its pointer at base+8*i+4. The low three bits of the written base are ignored. Status bit 31 is OWN, bit 30 is done, bit 29 is start-of-frame, bit 28 is end-of-frame, and bits 15:0 hold the byte length.
- R3: A descriptor whose OWN bit is 0 is not transferred and its memory is left untouched. The channel reads it again after the programmed re-read interval, and starts work once OWN reads 1.
- R4: Transmit sends exactly the length in bytes from the buffer. Bytes are taken from each 32-bit word least significant byte first, and the low two pointer bits are ignored. `out_last` is high on the final byte only, and a length of 0 sends nothing.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R6: After transmit, the status word is written back with OWN=0, done=1 and bits 29:0 unchanged.
- R7: Receive stores stream bytes from the pointer onward, least significant byte first, writing only the byte lanes received. The status is written back with OWN=0, done=1, start=1, end=1, bits 27:16 kept, and the stored byte count in bits 15:0.
- R8: In receive, bytes beyond the length capacity of the descriptor are accepted but discarded. The written-back length saturates at the capacity, and memory past the capacity is not written.
- R9: The index advances after each write-back. It wraps to 0 after slot length-1, and a length of 0 or 1 keeps it at 0.
- R10: Clearing control bit 0 lets a descriptor in transfer finish and write back, after which no further descriptor is fetched. If the channel is waiting on an idle descriptor, clearing the bit stops it at once.
- R11: Writing control bit 1 abandons any activity and returns the index to 0 on the next cycle. Bit 0 of the same write sets the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register select |
| reg_wdata | input | 32 | register write data |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | memory write (1) or read (0) |
| mem_addr | output | 32 | memory byte address, word aligned |
| mem_be | output | 4 | byte enables for writes |
| mem_wdata | output | 32 | memory write data |
| mem_rdata | input | 32 | memory read data, valid one cycle after a read request |
| out_valid | output | 1 | transmit byte valid |
| out_data | output | 8 | transmit byte |
| out_last | output | 1 | final byte of the frame |
| out_ready | input | 1 | transmit sink accepts |
| in_valid | input | 1 | receive byte valid |
| in_data | input | 8 | receive byte |
| in_last | input | 1 | final byte of the received frame |
| in_ready | output | 1 | channel accepts a receive byte |

## Verification
The assertions check four properties on every cycle:
- every write-back carries OWN=0 and done=1;
- the transmit stream holds steady under back-pressure;
- the ring index stays inside the programmed length and returns to 0 after a reset write;
- the receive byte count never exceeds the descriptor capacity.

Other behaviour can only be shown by the directed scenarios:
- byte ordering and exact lane enables;
- the re-read of idle descriptors;
- truncation leaving memory past the capacity untouched;
- ring wrap;
- the difference between disabling during a transfer and disabling while idle.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RDST, S_STW, S_CHK, S_POLL, S_RDPTR, S_PTW, S_GETPTR,
    S_TXRD, S_TXW, S_TXLD, S_TXOUT, S_RXIN, S_RXWR, S_WB
  } chan_st_e;

  localparam int BIT_OWN  = 31;
  localparam int BIT_DONE = 30;
  localparam int BIT_SOF  = 29;
  localparam int BIT_EOF  = 28;

  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_LEN  = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_POLL = 2'd3;
endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
  import ring_dma_pkg::*;
#(
  parameter int LEN_W    = 5,
  parameter int POLL_W   = 16,
  parameter int POLL_DEF = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       desc_base,
  output logic [LEN_W-1:0]  ring_len,
  output logic              chan_en,
  output logic              chan_rst,
  output logic [POLL_W-1:0] poll_ivl
);
  logic [28:0] base_hi;

  // descriptor base is kept 8-byte aligned
  assign desc_base = {base_hi, 3'b000};
  assign chan_rst  = reg_we && (reg_addr == RA_CTRL) && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi  <= '0;
      ring_len <= '0;
      chan_en  <= 1'b0;
      poll_ivl <= POLL_W'(POLL_DEF);
    end else if (reg_we) begin
      case (reg_addr)
        RA_BASE: base_hi  <= reg_wdata[31:3];
        RA_LEN:  ring_len <= reg_wdata[LEN_W-1:0];
        RA_CTRL: chan_en  <= reg_wdata[0];
        default: poll_ivl <= reg_wdata[POLL_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/ring_index.sv
module ring_index #(
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [LEN_W-1:0] ring_len,
  output logic [IDX_W-1:0] idx
);
  logic [LEN_W-1:0] nxt;
  assign nxt = LEN_W'(idx) + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr)
      idx <= '0;
    else if (adv)
      idx <= (nxt >= ring_len) ? '0 : idx + IDX_W'(1);
  end
endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter bit RX_MODE  = 1'b0,
  parameter int IDX_W    = 4,
  parameter int POLL_W   = 16,
  parameter int POLL_DEF = 16
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready
);
  localparam int LEN_W = IDX_W + 1;

  logic [31:0]       desc_base;
  logic [LEN_W-1:0]  ring_len;
  logic              chan_en, chan_rst;
  logic [POLL_W-1:0] poll_ivl, poll_cnt;
  logic [IDX_W-1:0]  cur_idx;
  logic [31:0]       desc_addr;
  chan_st_e          st;
  logic [31:0]       status_q, buf_addr, wbuf;
  logic [15:0]       rem, rx_cnt, rx_cap;
  logic [3:0]        wbe;
  logic              pend_last, wb_cyc;

  ring_cfg_regs #(.LEN_W(LEN_W), .POLL_W(POLL_W), .POLL_DEF(POLL_DEF)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .desc_base(desc_base), .ring_len(ring_len), .chan_en(chan_en),
    .chan_rst(chan_rst), .poll_ivl(poll_ivl)
  );

  ring_index #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_idx (
    .clk(clk), .rst(rst), .clr(chan_rst), .adv(wb_cyc),
    .ring_len(ring_len), .idx(cur_idx)
  );

  assign desc_addr = desc_base + {{(29-IDX_W){1'b0}}, cur_idx, 3'b000};
  assign wb_cyc    = (st == S_WB);
  assign rx_cap    = status_q[15:0];

  generate
    if (RX_MODE) begin : g_rx
      assign in_ready = (st == S_RXIN);
    end else begin : g_tx
      assign in_ready = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || chan_rst) begin
      st        <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      poll_cnt  <= '0;
      status_q  <= '0;
      buf_addr  <= '0;
      wbuf      <= '0;
      rem       <= '0;
      rx_cnt    <= '0;
      wbe       <= '0;
      pend_last <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      case (st)
        S_IDLE: if (chan_en) st <= S_RDST;
        S_RDST: begin
          mem_req  <= 1'b1;
          mem_addr <= desc_addr;
          st       <= S_STW;
        end
        S_STW: st <= S_CHK;
        S_CHK: begin
          status_q <= mem_rdata;
          if (mem_rdata[BIT_OWN]) st <= S_RDPTR;
          else begin
            poll_cnt <= poll_ivl;
            st       <= S_POLL;
          end
        end
        S_POLL: begin
          if (!chan_en)            st <= S_IDLE;
          else if (poll_cnt == '0) st <= S_RDST;
          else                     poll_cnt <= poll_cnt - 1'b1;
        end
        S_RDPTR: begin
          mem_req  <= 1'b1;
          mem_addr <= desc_addr + 32'd4;
          st       <= S_PTW;
        end
        S_PTW: st <= S_GETPTR;
        S_GETPTR: begin
          buf_addr <= {mem_rdata[31:2], 2'b00};
          rem      <= status_q[15:0];
          rx_cnt   <= '0;
          wbe      <= '0;
          if (RX_MODE)                    st <= S_RXIN;
          else if (status_q[15:0] == '0)  st <= S_WB;
          else                            st <= S_TXRD;
        end
        S_TXRD: begin
          mem_req  <= 1'b1;
          mem_addr <= buf_addr;
          st       <= S_TXW;
        end
        S_TXW: st <= S_TXLD;
        S_TXLD: begin
          wbuf      <= mem_rdata;
          out_valid <= 1'b1;
          out_data  <= mem_rdata[7:0];
          out_last  <= (rem == 16'd1);
          st        <= S_TXOUT;
        end
        S_TXOUT: if (out_ready) begin
          rem <= rem - 1'b1;
          if (rem == 16'd1) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            st        <= S_WB;
          end else if (buf_addr[1:0] == 2'd3) begin
            out_valid <= 1'b0;
            buf_addr  <= {buf_addr[31:2] + 30'd1, 2'b00};
            st        <= S_TXRD;
          end else begin
            buf_addr[1:0] <= buf_addr[1:0] + 2'd1;
            wbuf          <= wbuf >> 8;
            out_data      <= wbuf[15:8];
            out_last      <= (rem == 16'd2);
          end
        end
        S_RXIN: if (in_valid) begin
          if (rx_cnt < rx_cap) begin
            wbuf[8*rx_cnt[1:0] +: 8] <= in_data;
            wbe[rx_cnt[1:0]]         <= 1'b1;
            rx_cnt                   <= rx_cnt + 16'd1;
            if (rx_cnt[1:0] == 2'd3 || in_last || (rx_cnt + 16'd1) == rx_cap) begin
              pend_last <= in_last;
              st        <= S_RXWR;
            end
          end else if (in_last) begin
            st <= S_WB;
          end
        end
        S_RXWR: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= buf_addr;
          mem_be    <= wbe;
          mem_wdata <= wbuf;
          wbe       <= '0;
          buf_addr  <= buf_addr + 32'd4;
          st        <= pend_last ? S_WB : S_RXIN;
        end
        S_WB: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b1;
          mem_be   <= 4'hF;
          mem_addr <= desc_addr;
          if (RX_MODE) mem_wdata <= {1'b0, 1'b1, 1'b1, 1'b1, status_q[27:16], rx_cnt};
          else         mem_wdata <= {1'b0, 1'b1, status_q[29:0]};
          rx_cnt   <= '0;
          st       <= chan_en ? S_RDST : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_dma_chk.sv
module ring_dma_chk
  import ring_dma_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
)(
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_wdata,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [7:0]       out_data,
  input logic             wb_cyc,
  input logic [IDX_W-1:0] cur_idx,
  input logic [LEN_W-1:0] ring_len,
  input logic [15:0]      rx_cnt,
  input logic [15:0]      rx_cap
);
  logic soft_rst;
  assign soft_rst = reg_we && (reg_addr == RA_CTRL) && reg_wdata[1];

  // R6 and R7: write-back returns ownership and marks done
  assert_wb_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !soft_rst) |=> (mem_req && mem_we && !mem_wdata[BIT_OWN] && mem_wdata[BIT_DONE]));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !soft_rst) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  assert_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
    (cur_idx == '0) || (LEN_W'(cur_idx) < ring_len));

  assert_rst_idx_R11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cur_idx == '0));

  assert_rx_sat_R8: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= rx_cap);
endmodule

bind ring_dma_chan ring_dma_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last), .out_data(out_data),
  .wb_cyc(wb_cyc), .cur_idx(cur_idx), .ring_len(ring_len),
  .rx_cnt(rx_cnt), .rx_cap(rx_cap)
);

// File: tb/ring_dma_chan_tb_top.sv
module ring_dma_chan_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // ---------------- transmit instance ----------------
  logic        t_we = 0;
  logic [1:0]  t_ra = 0;
  logic [31:0] t_wd = 0;
  logic        t_mreq, t_mwe;
  logic [31:0] t_maddr, t_mwdata;
  logic [31:0] t_mrdata = 0;
  logic [3:0]  t_mbe;
  logic        t_ov, t_ol, t_ir_unused;
  logic [7:0]  t_od;
  logic        t_or = 1'b1;

  ring_dma_chan #(.RX_MODE(1'b0), .IDX_W(4), .POLL_W(16), .POLL_DEF(16)) dut_i (
    .clk(clk), .rst(rst), .reg_we(t_we), .reg_addr(t_ra), .reg_wdata(t_wd),
    .mem_req(t_mreq), .mem_we(t_mwe), .mem_addr(t_maddr), .mem_be(t_mbe),
    .mem_wdata(t_mwdata), .mem_rdata(t_mrdata),
    .out_valid(t_ov), .out_data(t_od), .out_last(t_ol), .out_ready(t_or),
    .in_valid(1'b0), .in_data(8'h00), .in_last(1'b0), .in_ready(t_ir_unused)
  );

  logic [31:0] tmem [0:1023];
  logic        tp_en = 0;
  logic [9:0]  tp_a  = 0;
  logic [31:0] tp_d  = 0;
  always @(posedge clk) begin
    if (tp_en) tmem[tp_a] <= tp_d;
    if (t_mreq) begin
      if (t_mwe) begin
        for (int b = 0; b < 4; b++)
          if (t_mbe[b]) tmem[t_maddr[11:2]][8*b +: 8] <= t_mwdata[8*b +: 8];
      end else t_mrdata <= tmem[t_maddr[11:2]];
    end
  end

  logic [7:0] cap_d [0:63];
  logic       cap_l [0:63];
  int         cap_n = 0;
  always @(posedge clk) begin
    if (t_ov && t_or && cap_n < 64) begin
      cap_d[cap_n] <= t_od;
      cap_l[cap_n] <= t_ol;
      cap_n        <= cap_n + 1;
    end
  end

  // ---------------- receive instance ----------------
  logic        r_we = 0;
  logic [1:0]  r_ra = 0;
  logic [31:0] r_wd = 0;
  logic        r_mreq, r_mwe;
  logic [31:0] r_maddr, r_mwdata;
  logic [31:0] r_mrdata = 0;
  logic [3:0]  r_mbe;
  logic        r_ov_unused, r_ol_unused;
  logic [7:0]  r_od_unused;
  logic        r_iv = 0, r_il = 0, r_ir;
  logic [7:0]  r_id = 0;

  ring_dma_chan #(.RX_MODE(1'b1), .IDX_W(4), .POLL_W(16), .POLL_DEF(16)) dut_rx_i (
    .clk(clk), .rst(rst), .reg_we(r_we), .reg_addr(r_ra), .reg_wdata(r_wd),
    .mem_req(r_mreq), .mem_we(r_mwe), .mem_addr(r_maddr), .mem_be(r_mbe),
    .mem_wdata(r_mwdata), .mem_rdata(r_mrdata),
    .out_valid(r_ov_unused), .out_data(r_od_unused), .out_last(r_ol_unused), .out_ready(1'b1),
    .in_valid(r_iv), .in_data(r_id), .in_last(r_il), .in_ready(r_ir)
  );

  logic [31:0] rmem [0:1023];
  logic        rp_en = 0;
  logic [9:0]  rp_a  = 0;
  logic [31:0] rp_d  = 0;
  always @(posedge clk) begin
    if (rp_en) rmem[rp_a] <= rp_d;
    if (r_mreq) begin
      if (r_mwe) begin
        for (int b = 0; b < 4; b++)
          if (r_mbe[b]) rmem[r_maddr[11:2]][8*b +: 8] <= r_mwdata[8*b +: 8];
      end else r_mrdata <= rmem[r_maddr[11:2]];
    end
  end

  // back-pressure pattern on the transmit stream
  bit stall_en = 1'b0;
  int cyc = 0;
  initial forever begin
    @(negedge clk);
    cyc++;
    t_or = !(stall_en && (cyc % 3 == 0));
  end

  // ---------------- helpers ----------------
  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic t_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); t_we = 1; t_ra = a; t_wd = d;
    @(negedge clk); t_we = 0;
  endtask

  task automatic r_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); r_we = 1; r_ra = a; r_wd = d;
    @(negedge clk); r_we = 0;
  endtask

  task automatic t_poke(int w, logic [31:0] d);
    @(negedge clk); tp_en = 1; tp_a = 10'(w); tp_d = d;
    @(negedge clk); tp_en = 0;
  endtask

  task automatic r_poke(int w, logic [31:0] d);
    @(negedge clk); rp_en = 1; rp_a = 10'(w); rp_d = d;
    @(negedge clk); rp_en = 0;
  endtask

  task automatic wait_cap(int n);
    int k = 0;
    while (cap_n < n && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(int n, logic [7:0] first);
    for (int i = 0; i < n; i++) begin
      int k = 0;
      @(negedge clk);
      r_iv = 1; r_id = first + 8'(i); r_il = (i == n - 1);
      while (!r_ir && k < 3000) begin @(negedge clk); k++; end
    end
    @(negedge clk);
    r_iv = 0; r_il = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic test_reset();
    wait_cycles(3);
    chk("R1 tx mem_req after reset", 32'(t_mreq), 0);
    chk("R1 tx out_valid after reset", 32'(t_ov), 0);
    chk("R1 rx in_ready after reset", 32'(r_ir), 0);
    chk("R1 rx mem_req after reset", 32'(r_mreq), 0);
  endtask

  task automatic test_tx_basic();
    t_poke(64, 32'hB000_0005); t_poke(65, 32'h0000_0402);
    t_poke(66, 32'hB5A5_0008); t_poke(67, 32'h0000_0440);
    t_poke(68, 32'h3000_0003); t_poke(69, 32'h0000_0480);
    t_poke(256, 32'h4433_2211); t_poke(257, 32'h8877_6655);
    t_poke(272, 32'hA3A2_A1A0); t_poke(273, 32'hA7A6_A5A4);
    t_poke(288, 32'h00C2_C1C0);
    t_reg(2'd2, 32'h2);
    t_reg(2'd0, 32'h0000_0105);   // R2: low bits of the base ignored
    t_reg(2'd1, 32'd3);
    t_reg(2'd3, 32'd20);
    t_reg(2'd2, 32'h1);
    wait_cap(13);
    chk("R4 byte count two frames", 32'(cap_n), 13);
    for (int i = 0; i < 5; i++)
      chk($sformatf("R4 frame0 byte %0d", i), 32'(cap_d[i]), 32'(8'h11 * (i + 1)));
    for (int i = 0; i < 8; i++)
      chk($sformatf("R4 frame1 byte %0d", i), 32'(cap_d[5+i]), 32'(8'hA0 + i));
    chk("R4 last on frame0 end", 32'(cap_l[4]), 1);
    chk("R4 last not mid-frame", 32'(cap_l[3]), 0);
    chk("R4 last on frame1 end", 32'(cap_l[12]), 1);
    wait_cycles(10);
    chk("R6 d0 written back", tmem[64], 32'h7000_0005);
    chk("R6 d1 written back", tmem[66], 32'h75A5_0008);
  endtask

  task automatic test_tx_poll_wrap();
    wait_cycles(100);
    chk("R3 idle desc untouched", tmem[68], 32'h3000_0003);
    chk("R3 idle desc sends nothing", 32'(cap_n), 13);
    t_poke(68, 32'hB000_0003);
    wait_cap(16);
    chk("R3 pickup byte0", 32'(cap_d[13]), 32'hC0);
    chk("R3 pickup byte2", 32'(cap_d[15]), 32'hC2);
    wait_cycles(10);
    chk("R6 d2 written back", tmem[68], 32'h7000_0003);
    t_poke(64, 32'hB000_0002);
    wait_cap(18);
    chk("R9 wrap to slot 0 byte0", 32'(cap_d[16]), 32'h11);
    chk("R9 wrap to slot 0 byte1", 32'(cap_d[17]), 32'h22);
  endtask

  task automatic test_tx_disable();
    int k = 0;
    t_reg(2'd2, 32'h0);
    t_poke(66, 32'hB000_0004);
    wait_cycles(200);
    chk("R10 disabled while idle: no bytes", 32'(cap_n), 18);
    chk("R10 disabled while idle: desc kept", tmem[66], 32'hB000_0004);
    t_poke(68, 32'hB000_0002);
    stall_en = 1'b1;
    @(negedge clk); t_we = 1; t_ra = 2'd2; t_wd = 32'h1;
    @(negedge clk); t_we = 0;
    while (cap_n < 19 && k < 3000) begin @(negedge clk); k++; end
    @(negedge clk); t_we = 1; t_ra = 2'd2; t_wd = 32'h0;
    @(negedge clk); t_we = 0;
    wait_cycles(200);
    chk("R10 current frame finished", 32'(cap_n), 22);
    chk("R10 current desc written back", tmem[66], 32'h7000_0004);
    chk("R10 next desc not fetched", tmem[68], 32'hB000_0002);
    chk("R5 byte order under stall", 32'(cap_d[21]), 32'hA3);
  endtask

  task automatic test_tx_reset_bit();
    t_poke(64, 32'hB000_0001);
    t_reg(2'd2, 32'h3);   // R11: index back to 0 and enable
    wait_cap(23);
    chk("R11 restart at slot 0", 32'(cap_d[22]), 32'h11);
    wait_cycles(100);
    chk("R11 slot 2 skipped", tmem[68], 32'hB000_0002);
    chk("R11 single byte", 32'(cap_n), 23);
    t_poke(66, 32'hB000_0000);
    wait_cap(25);
    chk("R4 zero length sends nothing", 32'(cap_d[23]), 32'hC0);
    chk("R6 zero length written back", tmem[66], 32'h7000_0000);
    wait_cycles(10);
    chk("R9 slot 2 done after zero length", tmem[68], 32'h7000_0002);
  endtask

  task automatic test_rx();
    int seen = 0;
    r_poke(128, 32'h8123_0600); r_poke(129, 32'h0000_0600);
    r_poke(130, 32'h8000_0004); r_poke(131, 32'h0000_0680);
    for (int i = 0; i < 3; i++) r_poke(384 + i, 32'hDEAD_BEEF);
    for (int i = 0; i < 3; i++) r_poke(416 + i, 32'hDEAD_BEEF);
    r_reg(2'd2, 32'h2);
    r_reg(2'd0, 32'h0000_0200);
    r_reg(2'd1, 32'd2);
    r_reg(2'd3, 32'd10);
    r_reg(2'd2, 32'h1);
    send_rx(7, 8'h10);
    wait_cycles(10);
    chk("R7 rx word0", rmem[384], 32'h1312_1110);
    chk("R7 rx partial word lanes", rmem[385], 32'hDE16_1514);
    chk("R7 rx beyond frame", rmem[386], 32'hDEAD_BEEF);
    chk("R7 rx status", rmem[128], 32'h7123_0007);
    send_rx(10, 8'h30);
    wait_cycles(10);
    chk("R8 stored up to capacity", rmem[416], 32'h3332_3130);
    chk("R8 past capacity untouched", rmem[417], 32'hDEAD_BEEF);
    chk("R8 length saturated", rmem[130], 32'h7000_0004);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (r_ir) seen++;
    end
    chk("R3 rx idle desc not accepting", 32'(seen), 0);
    r_poke(128, 32'h8000_0600);
    send_rx(3, 8'h50);
    wait_cycles(10);
    chk("R3 R9 rx rearmed slot 0 data", rmem[384], 32'h1352_5150);
    chk("R3 R9 rx rearmed slot 0 status", rmem[128], 32'h7000_0003);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_tx_basic();
    test_tx_poll_wrap();
    test_tx_disable();
    test_tx_reset_bit();
    test_rx();
    finish_run();
  end
endmodule